// File: doc/BRIEF.md
# Shifter Operand Unit

This block produces the second operand of a 32-bit data-processing datapath together with the shifter carry. It is purely combinational. A register value can be shifted or rotated by an amount taken from a 5-bit instruction field or from the low byte of a second register. Alternatively, an 8-bit constant can be rotated right by twice a 4-bit field. The block settles every zero-amount and oversized-amount case, so the ALU that follows only ever sees a final operand and a final carry.

The amount source selector picks the form:

- 0: immediate amount.
- 1: register amount.
- 2: rotated constant. Code 3 behaves like code 2.

The shift kind uses these codes:

- 0: logical left.
- 1: logical right.
- 2: arithmetic right.
- 3: rotate right.

Two flags mark that the operand register or the amount register is the program counter. The flags take effect only in the register-amount form.

Top module: `shifter_operand_unit`

## Requirements
- R1: With an immediate amount of 1 to 31, kinds 0/1/2/3 give logical left, logical right, arithmetic right and rotate right of the register value. The carry is the last bit moved out.
- R2: With an immediate amount of 0, logical right and arithmetic right act as a shift by 32. Logical right gives 0 and arithmetic right gives copies of bit 31. In both cases the carry is bit 31.
- R3: With an immediate amount of 0, rotate right becomes a one-bit rotate through carry. The result is {carry_in, value[31:1]} and the carry is value[0].
- R4: With an immediate amount of 0, logical left passes the value through unchanged, and carry_out equals carry_in.
- R5: In the register-amount form only bits 7:0 of the amount register count. An effective amount of 0 passes the operand through for every kind, with carry_out equal to carry_in.
- R6: A register-amount logical shift by exactly 32 gives 0, with carry equal to the last bit shifted out (bit 0 for left, bit 31 for right). Amounts from 33 to 255 give 0 with carry 0.
- R7: A register-amount arithmetic right shift by 32 to 255 fills the result with bit 31, and the carry equals bit 31.
- R8: A register-amount rotate uses the amount modulo 32. A nonzero multiple of 32 returns the operand unchanged, with carry equal to bit 31. For any other nonzero amount the carry is the result's bit 31.
- R9: In the rotated-constant form the zero-extended 8-bit constant is rotated right by twice the 4-bit field. A field of 0 gives carry_out equal to carry_in. Otherwise carry_out is bit 31 of the result.
- R10: In the register-amount form, a program-counter operand or amount register is read as its value plus 4. In the other forms both flags have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| amt_src | input | 2 | Amount source: 0 immediate, 1 register, 2/3 rotated constant |
| sh_kind | input | 2 | Shift kind: 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| opnd_reg | input | 32 | Register value to be shifted |
| opnd_is_pc | input | 1 | Operand register is the program counter |
| imm_amt | input | 5 | Immediate shift amount field |
| amt_reg | input | 32 | Amount register value (low byte used) |
| amt_is_pc | input | 1 | Amount register is the program counter |
| rot_field | input | 4 | Rotate field for the constant form |
| imm_const | input | 8 | 8-bit constant for the constant form |
| carry_in | input | 1 | Current carry flag |
| shift_out | output | 32 | Shifted operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The assertions assume that every input is a defined 0/1 value whenever they are evaluated, and that the internal amount and kind wires reflect the current inputs once the combinational logic has settled. They treat selector code 3 as an alias of the constant form and do not exercise it separately. The stimulus changes inputs only on the rising clock edge and compares outputs on the falling edge, so every value is settled before it is checked. The stimulus never drives selector code 3, so the alias is not covered. Random patterns draw only from the three documented forms and from full-range register and amount values.

// File: rtl/shop_pkg.sv
package shop_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned AW       = 8;
  localparam int unsigned IW       = 5;
  localparam int unsigned RW       = 4;
  localparam int unsigned CW       = 8;
  localparam int unsigned PC_AHEAD = 4;

  typedef enum logic [1:0] {SH_LSL = 2'd0, SH_LSR = 2'd1, SH_ASR = 2'd2, SH_ROR = 2'd3} sh_kind_e;
  typedef enum logic [1:0] {SRC_IMM = 2'd0, SRC_REG = 2'd1, SRC_CONST = 2'd2, SRC_ALIAS = 2'd3} amt_src_e;

  typedef struct packed {
    logic [DW-1:0] val;
    logic          c;
  } sh_res_t;

  function automatic sh_res_t f_lsl(logic [DW-1:0] x, logic [AW-1:0] n, logic cin);
    sh_res_t r;
    logic [DW:0] t;
    t = {1'b0, x} << n;
    if (n == '0) begin
      r.val = x; r.c = cin;
    end else if (n > AW'(DW)) begin
      r.val = '0; r.c = 1'b0;
    end else begin
      r.val = t[DW-1:0]; r.c = t[DW];
    end
    return r;
  endfunction

  function automatic sh_res_t f_lsr(logic [DW-1:0] x, logic [AW-1:0] n, logic cin);
    sh_res_t r;
    logic [DW:0] t;
    t = {x, 1'b0} >> n;
    if (n == '0) begin
      r.val = x; r.c = cin;
    end else if (n > AW'(DW)) begin
      r.val = '0; r.c = 1'b0;
    end else begin
      r.val = t[DW:1]; r.c = t[0];
    end
    return r;
  endfunction

  function automatic sh_res_t f_asr(logic [DW-1:0] x, logic [AW-1:0] n, logic cin);
    sh_res_t r;
    logic [DW:0] t;
    t = $unsigned($signed({x, 1'b0}) >>> n);
    if (n == '0) begin
      r.val = x; r.c = cin;
    end else if (n >= AW'(DW)) begin
      r.val = {DW{x[DW-1]}}; r.c = x[DW-1];
    end else begin
      r.val = t[DW:1]; r.c = t[0];
    end
    return r;
  endfunction

  function automatic sh_res_t f_ror(logic [DW-1:0] x, logic [AW-1:0] n, logic cin);
    sh_res_t r;
    logic [2*DW-1:0] d;
    d = {x, x} >> n[$clog2(DW)-1:0];
    if (n == '0) begin
      r.val = x; r.c = cin;
    end else begin
      r.val = d[DW-1:0]; r.c = d[DW-1];
    end
    return r;
  endfunction

  function automatic sh_res_t f_rrx(logic [DW-1:0] x, logic cin);
    sh_res_t r;
    r.val = {cin, x[DW-1:1]};
    r.c   = x[0];
    return r;
  endfunction
endpackage

// File: rtl/shop_amount.sv
module shop_amount
  import shop_pkg::*;
(
  input  logic [1:0]    amt_src,
  input  logic [1:0]    sh_kind,
  input  logic [DW-1:0] opnd_reg,
  input  logic          opnd_is_pc,
  input  logic [IW-1:0] imm_amt,
  input  logic [DW-1:0] amt_reg,
  input  logic          amt_is_pc,
  input  logic [RW-1:0] rot_field,
  input  logic [CW-1:0] imm_const,
  output logic [DW-1:0] eff_opnd,
  output logic [AW-1:0] eff_amt,
  output logic [1:0]    eff_kind,
  output logic          eff_rrx
);
  localparam logic [DW-1:0] PC_ADJ = DW'(PC_AHEAD);

  logic [DW-1:0] amt_full;

  always_comb begin
    amt_full = amt_reg + (amt_is_pc ? PC_ADJ : '0);
    eff_opnd = opnd_reg;
    eff_amt  = AW'(imm_amt);
    eff_kind = sh_kind;
    eff_rrx  = 1'b0;
    unique case (amt_src_e'(amt_src))
      SRC_IMM: begin
        if (imm_amt == '0) begin
          if (sh_kind == SH_LSR || sh_kind == SH_ASR) eff_amt = AW'(DW);
          if (sh_kind == SH_ROR) eff_rrx = 1'b1;
        end
      end
      SRC_REG: begin
        eff_opnd = opnd_reg + (opnd_is_pc ? PC_ADJ : '0);
        eff_amt  = amt_full[AW-1:0];
      end
      default: begin
        eff_opnd = DW'(imm_const);
        eff_amt  = AW'({rot_field, 1'b0});
        eff_kind = SH_ROR;
      end
    endcase
  end
endmodule

// File: rtl/shop_core.sv
module shop_core
  import shop_pkg::*;
(
  input  logic [DW-1:0] eff_opnd,
  input  logic [AW-1:0] eff_amt,
  input  logic [1:0]    eff_kind,
  input  logic          eff_rrx,
  input  logic          carry_in,
  output logic [DW-1:0] shift_out,
  output logic          carry_out
);
  sh_res_t res;

  always_comb begin
    if (eff_rrx) begin
      res = f_rrx(eff_opnd, carry_in);
    end else begin
      unique case (sh_kind_e'(eff_kind))
        SH_LSL:  res = f_lsl(eff_opnd, eff_amt, carry_in);
        SH_LSR:  res = f_lsr(eff_opnd, eff_amt, carry_in);
        SH_ASR:  res = f_asr(eff_opnd, eff_amt, carry_in);
        default: res = f_ror(eff_opnd, eff_amt, carry_in);
      endcase
    end
    shift_out = res.val;
    carry_out = res.c;
  end
endmodule

// File: rtl/shifter_operand_unit.sv
module shifter_operand_unit
  import shop_pkg::*;
(
  input  logic [1:0]    amt_src,
  input  logic [1:0]    sh_kind,
  input  logic [DW-1:0] opnd_reg,
  input  logic          opnd_is_pc,
  input  logic [IW-1:0] imm_amt,
  input  logic [DW-1:0] amt_reg,
  input  logic          amt_is_pc,
  input  logic [RW-1:0] rot_field,
  input  logic [CW-1:0] imm_const,
  input  logic          carry_in,
  output logic [DW-1:0] shift_out,
  output logic          carry_out
);
  logic [DW-1:0] eff_opnd;
  logic [AW-1:0] eff_amt;
  logic [1:0]    eff_kind;
  logic          eff_rrx;

  shop_amount u_amt (
    .amt_src(amt_src), .sh_kind(sh_kind), .opnd_reg(opnd_reg), .opnd_is_pc(opnd_is_pc),
    .imm_amt(imm_amt), .amt_reg(amt_reg), .amt_is_pc(amt_is_pc), .rot_field(rot_field),
    .imm_const(imm_const), .eff_opnd(eff_opnd), .eff_amt(eff_amt), .eff_kind(eff_kind),
    .eff_rrx(eff_rrx)
  );

  shop_core u_core (
    .eff_opnd(eff_opnd), .eff_amt(eff_amt), .eff_kind(eff_kind), .eff_rrx(eff_rrx),
    .carry_in(carry_in), .shift_out(shift_out), .carry_out(carry_out)
  );
endmodule

// File: rtl/shop_checker.sv
module shop_checker
  import shop_pkg::*;
(
  input logic [1:0]    amt_src,
  input logic [1:0]    sh_kind,
  input logic [DW-1:0] opnd_reg,
  input logic [RW-1:0] rot_field,
  input logic          carry_in,
  input logic [DW-1:0] eff_opnd,
  input logic [AW-1:0] eff_amt,
  input logic [1:0]    eff_kind,
  input logic          eff_rrx,
  input logic [DW-1:0] shift_out,
  input logic          carry_out
);
  always_comb begin
    // R4
    no_shift_carry_chk: assert (eff_rrx || eff_amt != '0 || (carry_out == carry_in && shift_out == eff_opnd));
    // R3
    rrx_carry_chk: assert (!eff_rrx || (carry_out == opnd_reg[0] && shift_out[DW-1] == carry_in));
    // R9
    const_rot_carry_chk: assert (amt_src != SRC_CONST || rot_field == '0 || carry_out == shift_out[DW-1]);
    // R6
    big_logical_zero_chk: assert (!(amt_src == SRC_REG && (eff_kind == SH_LSL || eff_kind == SH_LSR)
                                    && eff_amt > AW'(DW)) || (shift_out == '0 && !carry_out));
    // R7
    asr_fill_chk: assert (!(amt_src == SRC_REG && sh_kind == SH_ASR && eff_amt >= AW'(DW))
                          || (shift_out == {DW{eff_opnd[DW-1]}} && carry_out == eff_opnd[DW-1]));
    // R8
    ror_whole_chk: assert (!(amt_src == SRC_REG && sh_kind == SH_ROR && eff_amt != '0
                             && eff_amt[$clog2(DW)-1:0] == '0)
                           || (shift_out == eff_opnd && carry_out == eff_opnd[DW-1]));
  end
endmodule

bind shifter_operand_unit shop_checker u_chk (
  .amt_src(amt_src), .sh_kind(sh_kind), .opnd_reg(opnd_reg), .rot_field(rot_field),
  .carry_in(carry_in), .eff_opnd(eff_opnd), .eff_amt(eff_amt), .eff_kind(eff_kind),
  .eff_rrx(eff_rrx), .shift_out(shift_out), .carry_out(carry_out)
);

// File: tb/shifter_operand_unit_tb.sv
module shifter_operand_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  amt_src = '0;
  logic [1:0]  sh_kind = '0;
  logic [31:0] opnd_reg = '0;
  logic        opnd_is_pc = 1'b0;
  logic [4:0]  imm_amt = '0;
  logic [31:0] amt_reg = '0;
  logic        amt_is_pc = 1'b0;
  logic [3:0]  rot_field = '0;
  logic [7:0]  imm_const = '0;
  logic        carry_in = 1'b0;
  logic [31:0] shift_out;
  logic        carry_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] val;
    logic        c;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  shifter_operand_unit u_dut (
    .amt_src(amt_src), .sh_kind(sh_kind), .opnd_reg(opnd_reg), .opnd_is_pc(opnd_is_pc),
    .imm_amt(imm_amt), .amt_reg(amt_reg), .amt_is_pc(amt_is_pc), .rot_field(rot_field),
    .imm_const(imm_const), .carry_in(carry_in), .shift_out(shift_out), .carry_out(carry_out)
  );

  // Bit-serial reference: one step per unit of amount, carry tracked per step
  function automatic exp_t model(logic [1:0] src, logic [1:0] k, logic [31:0] x, logic xpc,
                                 logic [4:0] ia, logic [31:0] ar, logic apc, logic [3:0] rf,
                                 logic [7:0] ic, logic cin);
    exp_t e;
    int   n;
    logic [31:0] v;
    logic c;
    logic [31:0] tmp;
    v = x; c = cin; n = 0;
    if (src == 2'd1) begin
      if (xpc) v = x + 32'd4;
      tmp = apc ? ar + 32'd4 : ar;
      n = int'(tmp[7:0]);
    end else if (src == 2'd0) begin
      n = int'(ia);
      if (ia == 0 && (k == 2'd1 || k == 2'd2)) n = 32;
      if (ia == 0 && k == 2'd3) begin
        e.val = {cin, x[31:1]}; e.c = x[0]; e.tag = ""; return e;
      end
    end else begin
      v = {24'd0, ic}; k = 2'd3; n = 2 * int'(rf);
    end
    for (int i = 0; i < n; i++) begin
      case (k)
        2'd0: begin c = v[31]; v = v << 1; end
        2'd1: begin c = v[0];  v = v >> 1; end
        2'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    e.val = v; e.c = c; e.tag = "";
    return e;
  endfunction

  task automatic drive(logic [1:0] src, logic [1:0] k, logic [31:0] x, logic xpc,
                       logic [4:0] ia, logic [31:0] ar, logic apc, logic [3:0] rf,
                       logic [7:0] ic, logic cin, string tag);
    exp_t e;
    @(posedge clk);
    amt_src = src; sh_kind = k; opnd_reg = x; opnd_is_pc = xpc; imm_amt = ia;
    amt_reg = ar; amt_is_pc = apc; rot_field = rf; imm_const = ic; carry_in = cin;
    e = model(src, k, x, xpc, ia, ar, apc, rf, ic, cin);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic drive_exp(logic [1:0] src, logic [1:0] k, logic [31:0] x, logic xpc,
                           logic [4:0] ia, logic [31:0] ar, logic apc, logic [3:0] rf,
                           logic [7:0] ic, logic cin, logic [31:0] ev, logic ec, string tag);
    exp_t e;
    @(posedge clk);
    amt_src = src; sh_kind = k; opnd_reg = x; opnd_is_pc = xpc; imm_amt = ia;
    amt_reg = ar; amt_is_pc = apc; rot_field = rf; imm_const = ic; carry_in = cin;
    e.val = ev; e.c = ec; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares settled outputs on the falling edge
  always @(negedge clk) begin
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_checks++;
      if (shift_out !== e.val || carry_out !== e.c) begin
        n_fail++;
        $display("FAIL %s: got %h/%b expected %h/%b", e.tag, shift_out, carry_out, e.val, e.c);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: all-zero inputs
    drive_exp(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, 1'b0, "reset");
    // R1
    drive_exp(0, 0, 32'h8000_0001, 0, 5'd4, 0, 0, 0, 0, 0, 32'h0000_0010, 1'b0, "R1 lsl4");
    drive_exp(0, 1, 32'h0000_0003, 0, 5'd1, 0, 0, 0, 0, 0, 32'h0000_0001, 1'b1, "R1 lsr1");
    drive_exp(0, 2, 32'h8000_0080, 0, 5'd8, 0, 0, 0, 0, 0, 32'hFF80_0000, 1'b1, "R1 asr8");
    drive_exp(0, 3, 32'h0000_0012, 0, 5'd4, 0, 0, 0, 0, 0, 32'h2000_0001, 1'b0, "R1 ror4");
    // R2
    drive_exp(0, 1, 32'h8000_0000, 0, 5'd0, 0, 0, 0, 0, 0, 32'h0, 1'b1, "R2 lsr0");
    drive_exp(0, 2, 32'h8000_0000, 0, 5'd0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 1'b1, "R2 asr0");
    // R3
    drive_exp(0, 3, 32'h0000_0003, 0, 5'd0, 0, 0, 0, 0, 1, 32'h8000_0001, 1'b1, "R3 rrx");
    drive_exp(0, 3, 32'h8000_0002, 0, 5'd0, 0, 0, 0, 0, 0, 32'h4000_0001, 1'b0, "R3 rrx c0");
    // R4
    drive_exp(0, 0, 32'hDEAD_BEEF, 0, 5'd0, 0, 0, 0, 0, 1, 32'hDEAD_BEEF, 1'b1, "R4 lsl0");
    // R5
    drive_exp(1, 0, 32'h1234_5678, 0, 0, 32'h0000_0100, 0, 0, 0, 1, 32'h1234_5678, 1'b1, "R5 lowbyte0");
    drive_exp(1, 1, 32'h1234_5678, 0, 0, 32'hFFFF_FF04, 0, 0, 0, 0, 32'h0123_4567, 1'b1, "R5 lowbyte4");
    drive_exp(1, 2, 32'h8000_0000, 0, 0, 32'h0, 0, 0, 0, 0, 32'h8000_0000, 1'b0, "R5 asr0");
    // R6
    drive_exp(1, 0, 32'h0000_0001, 0, 0, 32'd32, 0, 0, 0, 0, 32'h0, 1'b1, "R6 lsl32");
    drive_exp(1, 0, 32'hFFFF_FFFF, 0, 0, 32'd33, 0, 0, 0, 1, 32'h0, 1'b0, "R6 lsl33");
    drive_exp(1, 1, 32'h8000_0000, 0, 0, 32'd32, 0, 0, 0, 0, 32'h0, 1'b1, "R6 lsr32");
    drive_exp(1, 1, 32'hFFFF_FFFF, 0, 0, 32'd200, 0, 0, 0, 1, 32'h0, 1'b0, "R6 lsr200");
    // R7
    drive_exp(1, 2, 32'h8000_0001, 0, 0, 32'd32, 0, 0, 0, 0, 32'hFFFF_FFFF, 1'b1, "R7 asr32");
    drive_exp(1, 2, 32'h7FFF_FFFF, 0, 0, 32'd255, 0, 0, 0, 1, 32'h0, 1'b0, "R7 asr255");
    // R8
    drive_exp(1, 3, 32'h8000_0001, 0, 0, 32'd32, 0, 0, 0, 0, 32'h8000_0001, 1'b1, "R8 ror32");
    drive_exp(1, 3, 32'h7000_0000, 0, 0, 32'd64, 0, 0, 0, 1, 32'h7000_0000, 1'b0, "R8 ror64");
    drive_exp(1, 3, 32'h0000_0018, 0, 0, 32'd36, 0, 0, 0, 0, 32'h8000_0001, 1'b1, "R8 ror36");
    // R9
    drive_exp(2, 0, 0, 0, 0, 0, 0, 4'd0, 8'hFF, 1, 32'h0000_00FF, 1'b1, "R9 rot0");
    drive_exp(2, 0, 0, 0, 0, 0, 0, 4'd1, 8'hFF, 0, 32'hC000_003F, 1'b1, "R9 rot1");
    drive_exp(2, 1, 0, 0, 0, 0, 0, 4'd4, 8'h01, 1, 32'h0100_0000, 1'b0, "R9 rot4");
    // R10
    drive_exp(1, 0, 32'h0000_0100, 1, 0, 32'h0, 0, 0, 0, 0, 32'h0000_0104, 1'b0, "R10 opnd pc");
    drive_exp(1, 0, 32'h0000_0001, 0, 0, 32'h0, 1, 0, 0, 0, 32'h0000_0010, 1'b0, "R10 amt pc");
    drive_exp(0, 0, 32'h0000_0100, 1, 5'd0, 0, 1, 0, 0, 0, 32'h0000_0100, 1'b0, "R10 imm form ignores");
    drive_exp(2, 0, 32'h0000_0100, 1, 0, 0, 1, 4'd0, 8'h05, 0, 32'h0000_0005, 1'b0, "R10 const ignores");
    // R1 R5 R8 R9: random patterns against the serial model
    for (int i = 0; i < 60; i++) begin
      logic [1:0] s;
      s = 2'($urandom_range(0, 2));
      drive(s, 2'($urandom), $urandom, 1'($urandom), 5'($urandom), $urandom, 1'($urandom),
            4'($urandom), 8'($urandom), 1'($urandom), "R1 random");
    end
    while (sb.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule